// File: doc/BRIEF.md
# Interrupt-Capable Pin Controller

This block gives a processor register access to a group of general-purpose pins. For each pin, software picks a direction, sets the level that an output pin drives, and reads back the level present at the pad. A simple 32-bit register bus carries these accesses. Writes take effect on the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe and is held until the next read.

Each pin can also raise an interrupt. Three per-pin control words set the trigger: one chooses between edge and level, one sets the polarity, and one makes the pin fire on both edges. The both-edges word exists only when the build-time version number is greater than 2. Detected events are latched in a sticky status word. Software clears it by writing ones. A per-pin enable mask gates the status into a pending word, and one output line is raised when any enabled pin is pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are decoded at these byte addresses: pin level 0x00, direction 0x04, enable 0x08, status 0x0C, pending 0x10, clear 0x14, trigger type 0x18, polarity 0x1C, version 0x20, both-edges 0x24. Read data appears one cycle after the read strobe and holds while no read occurs. Bits at and above the pin count read as zero and are ignored on writes.
- R2: A direction bit of 1 makes the pin an input and drives its output enable low. A direction bit of 0 makes the pin an output: its output enable is high and it drives the matching bit of the output value word. Pins that are inputs drive 0. The direction word resets to all ones.
- R3: Writing address 0x00 sets the output value word. Reading address 0x00 returns the pin levels after a two-flop synchronizer.
- R4: A pin with trigger-type bit 0 is level-triggered. It is active-high when its polarity bit is 1 and active-low when it is 0. Its status bit is set again on every cycle the active level persists, so clearing it while the level is still active does not last.
- R5: A pin with trigger-type bit 1 and both-edges bit 0 latches its status on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. It ignores the opposite edge.
- R6: When the version parameter is above 2, a pin with both its trigger-type bit and its both-edges bit set latches status on any transition. When the version is 2 or lower, the both-edges word reads as zero and ignores writes.
- R7: Status bits stay set until they are cleared. Writing 1 to a bit at address 0x14 clears that status bit. Writing 0 has no effect. A trigger event in the same cycle as a clear wins, and the bit stays set.
- R8: The pending word is the status word ANDed with the enable word. The interrupt output is high exactly when the pending word is non-zero.
- R9: The enable word resets to zero. It changes only on a bus write to address 0x08, including when several pins trigger in the same cycle.
- R10: The version address reads back the version parameter. Writes to the version, status and pending addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pin_in | input | NPINS | Pad levels, asynchronous |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables, high for output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies side by side, both with 8 pins, on the same bus and pins. One copy uses version 3 and the other version 2. With 8 pins, writes of all ones show that the unused upper bits read as zero. Because both copies see identical stimulus, a rising edge on a pin configured for both edges gives a status bit in the version-3 copy and none in the version-2 copy, which checks the version gating at the ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_LEVEL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_DIR    = 6'h04;
    localparam logic [ADDR_W-1:0] A_ENABLE = 6'h08;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h0C;
    localparam logic [ADDR_W-1:0] A_PEND   = 6'h10;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 6'h14;
    localparam logic [ADDR_W-1:0] A_TTYPE  = 6'h18;
    localparam logic [ADDR_W-1:0] A_POLAR  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_VER    = 6'h20;
    localparam logic [ADDR_W-1:0] A_BOTH   = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] ttype,
    input  logic [W-1:0] polar,
    input  logic [W-1:0] both,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_on, edge_on;
        always_comb begin
            rise    = cur[i] & ~prev[i];
            fall    = ~cur[i] & prev[i];
            lvl_on  = polar[i] ? cur[i] : ~cur[i];
            if (both[i]) edge_on = rise | fall;
            else         edge_on = polar[i] ? rise : fall;
            hit[i]  = ttype[i] ? edge_on : lvl_on;
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int NPINS   = 32,
    parameter int VERSION = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_re,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    import gpio_pkg::*;

    localparam bit BOTH_ON = (VERSION > 2);

    typedef struct packed {
        logic [NPINS-1:0] val;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] sts;
        logic [NPINS-1:0] ttype;
        logic [NPINS-1:0] polar;
        logic [NPINS-1:0] both;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] lvl_cur, lvl_prev, hit;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .cur  (lvl_cur),
        .prev (lvl_prev)
    );

    gpio_detect #(.W(NPINS)) u_detect (
        .cur  (lvl_cur),
        .prev (lvl_prev),
        .ttype(r_q.ttype),
        .polar(r_q.polar),
        .both (r_q.both),
        .hit  (hit)
    );

    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] clr;
    assign wbits = bus_wdata[NPINS-1:0];

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (bus_we) begin
            case (bus_addr)
                A_LEVEL:  r_d.val   = wbits;
                A_DIR:    r_d.dir   = wbits;
                A_ENABLE: r_d.ien   = wbits;
                A_TTYPE:  r_d.ttype = wbits;
                A_POLAR:  r_d.polar = wbits;
                A_BOTH:   if (BOTH_ON) r_d.both = wbits;
                A_CLEAR:  clr       = wbits;
                default:  ;
            endcase
        end
        // a trigger in the same cycle as a clear keeps the bit set
        r_d.sts = (r_q.sts & ~clr) | hit;
        if (bus_re) begin
            case (bus_addr)
                A_LEVEL:  r_d.rdata = 32'(lvl_cur);
                A_DIR:    r_d.rdata = 32'(r_q.dir);
                A_ENABLE: r_d.rdata = 32'(r_q.ien);
                A_STATUS: r_d.rdata = 32'(r_q.sts);
                A_PEND:   r_d.rdata = 32'(r_q.sts & r_q.ien);
                A_TTYPE:  r_d.rdata = 32'(r_q.ttype);
                A_POLAR:  r_d.rdata = 32'(r_q.polar);
                A_VER:    r_d.rdata = 32'(VERSION);
                A_BOTH:   r_d.rdata = 32'(r_q.both);
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pin_oe    = ~r_q.dir;
    assign pin_out   = r_q.val & ~r_q.dir;
    assign irq       = |(r_q.sts & r_q.ien);
    assign bus_rdata = r_q.rdata;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic             bus_re,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] sts
);
    import gpio_pkg::*;

    // R9: enable word moves only on its own bus write
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_ENABLE) |=> $stable(ien));

    // R2: a direction write shows up inverted on the output enables
    a_r2_oe_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR) |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0])));

    // R7: without a clear write no status bit drops
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_CLEAR) |=> ((sts & $past(sts)) == $past(sts)));

    // R8: nothing enabled means no request
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R1: read data holds between reads
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .ien      (r_q.ien),
    .sts      (r_q.sts)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [5:0]  addr = '0;
    logic        we = 0;
    logic [31:0] wdata = '0;
    logic        re = 0;
    logic [7:0]  pin_in = 8'hFF;
    logic [31:0] rdata_a, rdata_b;
    logic [7:0]  pout_a, poe_a, pout_b, poe_b;
    logic        irq_a, irq_b;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NPINS(8), .VERSION(3)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata_a), .pin_in(pin_in), .pin_out(pout_a),
        .pin_oe(poe_a), .irq(irq_a));

    gpio_irq_ctrl #(.NPINS(8), .VERSION(2)) i_gpio_irq_ctrl_v2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata_b), .pin_in(pin_in), .pin_out(pout_b),
        .pin_oe(poe_b), .irq(irq_b));

    typedef struct {
        bit          which;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd(input bit which, input logic [5:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.which = which; it.exp = exp; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        addr = a; re = 1;
        @(negedge clk);
        re = 0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    // monitor: compares read data the cycle after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (re) begin
                item_t it;
                @(negedge clk);
                it = sb.pop_front();
                check(it.which ? rdata_b : rdata_a, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check(32'(poe_a), 32'h00, "R2 reset oe");
        check(32'(irq_a), 0, "R9 reset irq");
        rd(0, 6'h08, 32'h0, "R9 reset enable");
        rd(0, 6'h04, 32'hFF, "R2 reset dir");
        rd(0, 6'h20, 32'd3, "R10 version v3");
        rd(1, 6'h20, 32'd2, "R10 version v2");

        // direction and output value
        wr(6'h00, 32'hA5);
        wr(6'h04, 32'hF0);
        check(32'(poe_a), 32'h0F, "R2 oe");
        check(32'(pout_a), 32'h05, "R2 out");
        set_pins(8'h3C);
        rd(0, 6'h00, 32'h3C, "R3 level read");
        wr(6'h04, 32'hFF);
        check(32'(pout_a), 32'h00, "R2 inputs drive 0");
        set_pins(8'hFF);
        wr(6'h14, 32'hFF);
        rd(0, 6'h0C, 32'h0, "R7 clear all");

        // rising edge on pin0
        wr(6'h18, 32'h01);
        wr(6'h1C, 32'h01);
        wr(6'h08, 32'h01);
        set_pins(8'hFE);
        rd(0, 6'h0C, 32'h0, "R5 falling ignored");
        check(32'(irq_a), 0, "R8 no irq");
        set_pins(8'hFF);
        rd(0, 6'h0C, 32'h1, "R5 rising");
        rd(0, 6'h10, 32'h1, "R8 pending");
        check(32'(irq_a), 1, "R8 irq up");
        wr(6'h14, 32'h00);
        rd(0, 6'h0C, 32'h1, "R7 write zero no effect");
        wr(6'h14, 32'h01);
        rd(0, 6'h0C, 32'h0, "R7 write one clears");
        check(32'(irq_a), 0, "R8 irq down");

        // falling edge on pin1
        wr(6'h18, 32'h03);
        wr(6'h08, 32'h03);
        set_pins(8'hFD);
        rd(0, 6'h0C, 32'h2, "R5 falling");
        wr(6'h14, 32'h02);
        set_pins(8'hFF);
        rd(0, 6'h0C, 32'h0, "R5 rising ignored");

        // both edges on pin2
        wr(6'h18, 32'h07);
        wr(6'h24, 32'h04);
        rd(0, 6'h24, 32'h04, "R6 both word v3");
        rd(1, 6'h24, 32'h00, "R6 both word v2 ignored");
        set_pins(8'hFB);
        rd(0, 6'h0C, 32'h4, "R6 fall v3");
        rd(1, 6'h0C, 32'h4, "R6 fall v2");
        wr(6'h14, 32'h04);
        set_pins(8'hFF);
        rd(0, 6'h0C, 32'h4, "R6 rise v3");
        rd(1, 6'h0C, 32'h0, "R6 rise v2 ignored");
        wr(6'h14, 32'h04);

        // active-high level on pin3 (pin is high)
        wr(6'h1C, 32'h09);
        repeat (3) @(negedge clk);
        rd(0, 6'h0C, 32'h8, "R4 level high");
        wr(6'h14, 32'h08);
        rd(0, 6'h0C, 32'h8, "R4 clear while active");
        set_pins(8'hF7);
        wr(6'h14, 32'h08);
        rd(0, 6'h0C, 32'h0, "R4 clear after inactive");

        // active-low level on pin4, enable gating
        set_pins(8'hE7);
        rd(0, 6'h0C, 32'h10, "R4 level low");
        rd(0, 6'h10, 32'h00, "R8 pending masked");
        check(32'(irq_a), 0, "R8 masked irq");
        wr(6'h08, 32'h13);
        check(32'(irq_a), 1, "R8 irq after enable");
        rd(0, 6'h10, 32'h10, "R8 pending enabled");

        // two pins triggering together
        set_pins(8'hE1);
        rd(0, 6'h08, 32'h13, "R9 enable kept");
        rd(0, 6'h0C, 32'h16, "R7 simultaneous status");
        rd(0, 6'h10, 32'h12, "R8 simultaneous pending");

        // widths and read-only addresses
        wr(6'h08, 32'hFFFF_FFFF);
        rd(0, 6'h08, 32'hFF, "R1 upper bits zero");
        wr(6'h20, 32'h0);
        rd(0, 6'h20, 32'd3, "R10 version write ignored");
        wr(6'h0C, 32'h0);
        rd(0, 6'h0C, 32'h16, "R10 status write ignored");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule